// File: doc/BRIEF.md
# Sixty-four source interrupt register bank

This block holds the per-source state of a 64-input interrupt controller and makes it available on a 32-bit word-addressed register port. For every source it keeps a raw pending bit, an enable bit, a fast/normal type bit and a 4-bit priority. It also holds a 32-bit control word and a 5-bit normal-interrupt mask. Software changes this state through the register port. The 64 level inputs change the pending bits.

From that state the block derives two masked views, normal and fast, and drives a fast request line. The normal view, the priorities and the mask are handed to a separate arbiter, which picks the winning normal source and builds the vector. The two vector words therefore read as zero here. The vector-table address window accepts writes and discards them, except that its first word reads back a fixed constant.

Top module: `irq_regbank`

## Requirements
- R1: After reset, all pending, enable, type, priority and control bits are zero, the mask reads 0x1F, the fast request is low, and the read data register is zero.
- R2: When an input level differs from its value in the previous cycle, the matching pending bit takes the new level at the next clock. An input that holds steady leaves its pending bit untouched, so a forced value persists.
- R3: A write to byte 0x008 sets enable bit wdata[5:0], and a write to byte 0x00C clears that bit. Higher data bits are ignored, and both words read back as zero.
- R4: Enable high/low sit at bytes 0x010/0x014 and type high/low at 0x018/0x01C, where high means bits 63:32. The control word at 0x000 keeps all 32 bits. All of these read back what was written.
- R5: Priority words sit at bytes 0x020–0x03C in reversed group order. Byte 0x020 holds sources 56–63 and byte 0x03C holds sources 0–7. Source 8g+k occupies nibble bits 4k+3..4k of its word. These words read back as written, and `prio_all[4s+3:4s]` is the priority of source s.
- R6: A write to byte 0x050 (high) or 0x054 (low) replaces that half of the pending vector. It wins over an input change to the same bit in the same cycle, and both words read back as zero.
- R7: The normal view (pending AND enable AND NOT type) appears at bytes 0x058/0x05C (high/low) and on `norm_pend`. The fast view (pending AND enable AND type) appears at bytes 0x060/0x064 and on `fast_pend`. Raw pending reads at 0x048/0x04C.
- R8: `fiq_req` is high exactly when the fast view has any bit set.
- R9: A write to byte 0x004 keeps wdata[4:0] as the mask, and a read returns it zero-extended.
- R10: Writes to the read-only words (0x040–0x04C, 0x058–0x064) and to the vector window 0x100–0x2FC change nothing. A read at 0x100 returns 0x4, other vector-window reads return 0, and the vector words 0x040/0x044 read 0.
- R11: Reads of any unmapped address return zero, and writes to one change nothing.
- R12: `bus_rdata` is loaded on the clock edge where `bus_sel` is high and `bus_we` is low, and it holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| src_lvl | input | 64 | Level interrupt inputs |
| fiq_req | output | 1 | Fast interrupt request |
| norm_pend | output | 64 | Normal pending view for the arbiter |
| fast_pend | output | 64 | Fast pending view |
| prio_all | output | 256 | Packed 4-bit priorities, source 0 in the low nibble |
| nmask | output | 5 | Normal interrupt mask for the arbiter |

## Verification
Each state bit reaches the ports along two paths. One is a register read that lands one clock after the request. The other is the masked views and `fiq_req`, which follow a state change on the very next clock. A wrong pending, enable or type bit therefore shows up both in the views and in the raw readback within a cycle. A misplaced priority nibble shows up in the priority readback and in `prio_all`. A stray write decode shows up as a changed mask, enable or priority when the words are read back after a write to a read-only, vector or unmapped address. The forced-versus-input races are driven in the same cycle, and the result is read on the next one.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

    // word indices (byte address / 4) of the register map
    localparam int unsigned WI_CTL     = 0;
    localparam int unsigned WI_MASK    = 1;
    localparam int unsigned WI_ENNUM   = 2;
    localparam int unsigned WI_DISNUM  = 3;
    localparam int unsigned WI_EN_HI   = 4;
    localparam int unsigned WI_EN_LO   = 5;
    localparam int unsigned WI_TY_HI   = 6;
    localparam int unsigned WI_TY_LO   = 7;
    localparam int unsigned WI_PRIO_LO = 8;
    localparam int unsigned WI_PRIO_HI = 15;
    localparam int unsigned WI_NVEC    = 16;
    localparam int unsigned WI_FVEC    = 17;
    localparam int unsigned WI_RAW_HI  = 18;
    localparam int unsigned WI_RAW_LO  = 19;
    localparam int unsigned WI_FRC_HI  = 20;
    localparam int unsigned WI_FRC_LO  = 21;
    localparam int unsigned WI_NPND_HI = 22;
    localparam int unsigned WI_NPND_LO = 23;
    localparam int unsigned WI_FPND_HI = 24;
    localparam int unsigned WI_FPND_LO = 25;

    // vector table byte window
    localparam int unsigned VEC_BYTE_LO = 32'h100;
    localparam int unsigned VEC_BYTE_HI = 32'h2FC;
    localparam logic [31:0] VEC0_VALUE  = 32'h0000_0004;

    localparam logic [4:0] MASK_RESET = 5'h1F;

    typedef enum logic [4:0] {
        K_NONE,
        K_CTL,
        K_MASK,
        K_ENNUM,
        K_DISNUM,
        K_EN_HI,
        K_EN_LO,
        K_TY_HI,
        K_TY_LO,
        K_PRIO,
        K_NVEC,
        K_FVEC,
        K_RAW_HI,
        K_RAW_LO,
        K_FRC_HI,
        K_FRC_LO,
        K_NPND_HI,
        K_NPND_LO,
        K_FPND_HI,
        K_FPND_LO,
        K_VEC0,
        K_VECTAB
    } reg_kind_e;

endpackage

// File: rtl/irqb_decode.sv
module irqb_decode
    import irqb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int GRP_W  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [GRP_W-1:0]  grp
);

    logic [31:0] byte_a;
    logic [31:0] word_a;

    assign byte_a = 32'(addr);
    assign word_a = byte_a >> 2;

    always_comb begin
        kind = K_NONE;
        grp  = '0;
        if (byte_a >= VEC_BYTE_LO && byte_a <= VEC_BYTE_HI) begin
            kind = (byte_a == VEC_BYTE_LO) ? K_VEC0 : K_VECTAB;
        end else if (word_a >= WI_PRIO_LO && word_a <= WI_PRIO_HI) begin
            kind = K_PRIO;
            grp  = GRP_W'(WI_PRIO_HI - word_a);
        end else begin
            unique case (word_a)
                WI_CTL:     kind = K_CTL;
                WI_MASK:    kind = K_MASK;
                WI_ENNUM:   kind = K_ENNUM;
                WI_DISNUM:  kind = K_DISNUM;
                WI_EN_HI:   kind = K_EN_HI;
                WI_EN_LO:   kind = K_EN_LO;
                WI_TY_HI:   kind = K_TY_HI;
                WI_TY_LO:   kind = K_TY_LO;
                WI_NVEC:    kind = K_NVEC;
                WI_FVEC:    kind = K_FVEC;
                WI_RAW_HI:  kind = K_RAW_HI;
                WI_RAW_LO:  kind = K_RAW_LO;
                WI_FRC_HI:  kind = K_FRC_HI;
                WI_FRC_LO:  kind = K_FRC_LO;
                WI_NPND_HI: kind = K_NPND_HI;
                WI_NPND_LO: kind = K_NPND_LO;
                WI_FPND_HI: kind = K_FPND_HI;
                WI_FPND_LO: kind = K_FPND_LO;
                default:    kind = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/irqb_state.sv
module irqb_state
    import irqb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PRIO_W = 4,
    parameter int MASK_W = 5,
    parameter int GRP_W  = 3,
    localparam int NSRC   = 2 * DATA_W,
    localparam int HALF   = DATA_W,
    localparam int IDX_W  = $clog2(NSRC),
    localparam int NGRP   = (NSRC * PRIO_W) / DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_stb,
    input  reg_kind_e                kind,
    input  logic [GRP_W-1:0]         grp,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [NSRC-1:0]          src_lvl,
    output logic [NSRC-1:0]          pend_q,
    output logic [NSRC-1:0]          en_q,
    output logic [NSRC-1:0]          ty_q,
    output logic [NSRC*PRIO_W-1:0]   prio_q,
    output logic [DATA_W-1:0]        ctl_q,
    output logic [MASK_W-1:0]        mask_q
);

    logic [NSRC-1:0] src_prev;
    logic [NSRC-1:0] chg;
    logic [NSRC-1:0] pend_d;
    logic [NSRC-1:0] en_d;
    logic [NSRC-1:0] ty_d;
    logic [IDX_W-1:0] num;

    assign num = wdata[IDX_W-1:0];
    assign chg = src_lvl ^ src_prev;

    // pending: input edges first, a force write overrides its half
    always_comb begin
        pend_d = (pend_q & ~chg) | (src_lvl & chg);
        if (wr_stb && kind == K_FRC_HI) pend_d[NSRC-1:HALF] = wdata;
        if (wr_stb && kind == K_FRC_LO) pend_d[HALF-1:0]    = wdata;
    end

    always_comb begin
        en_d = en_q;
        ty_d = ty_q;
        if (wr_stb) begin
            unique case (kind)
                K_ENNUM:  en_d[num] = 1'b1;
                K_DISNUM: en_d[num] = 1'b0;
                K_EN_HI:  en_d[NSRC-1:HALF] = wdata;
                K_EN_LO:  en_d[HALF-1:0]    = wdata;
                K_TY_HI:  ty_d[NSRC-1:HALF] = wdata;
                K_TY_LO:  ty_d[HALF-1:0]    = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_prev <= '0;
            pend_q   <= '0;
            en_q     <= '0;
            ty_q     <= '0;
            ctl_q    <= '0;
            mask_q   <= MASK_RESET;
        end else begin
            src_prev <= src_lvl;
            pend_q   <= pend_d;
            en_q     <= en_d;
            ty_q     <= ty_d;
            if (wr_stb && kind == K_CTL)  ctl_q  <= wdata;
            if (wr_stb && kind == K_MASK) mask_q <= wdata[MASK_W-1:0];
        end
    end

    // one priority word per group of sources
    for (genvar g = 0; g < NGRP; g++) begin : g_prio
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prio_q[g*DATA_W +: DATA_W] <= '0;
            end else if (wr_stb && kind == K_PRIO && grp == GRP_W'(g)) begin
                prio_q[g*DATA_W +: DATA_W] <= wdata;
            end
        end
    end

endmodule

// File: rtl/irqb_rdmux.sv
module irqb_rdmux
    import irqb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PRIO_W = 4,
    parameter int MASK_W = 5,
    parameter int GRP_W  = 3,
    localparam int NSRC  = 2 * DATA_W,
    localparam int HALF  = DATA_W
) (
    input  reg_kind_e                kind,
    input  logic [GRP_W-1:0]         grp,
    input  logic [NSRC-1:0]          pend_q,
    input  logic [NSRC-1:0]          en_q,
    input  logic [NSRC-1:0]          ty_q,
    input  logic [NSRC*PRIO_W-1:0]   prio_q,
    input  logic [DATA_W-1:0]        ctl_q,
    input  logic [MASK_W-1:0]        mask_q,
    output logic [DATA_W-1:0]        rd_word
);

    logic [NSRC-1:0] nview;
    logic [NSRC-1:0] fview;

    assign nview = pend_q & en_q & ~ty_q;
    assign fview = pend_q & en_q & ty_q;

    always_comb begin
        unique case (kind)
            K_CTL:     rd_word = ctl_q;
            K_MASK:    rd_word = DATA_W'(mask_q);
            K_EN_HI:   rd_word = en_q[NSRC-1:HALF];
            K_EN_LO:   rd_word = en_q[HALF-1:0];
            K_TY_HI:   rd_word = ty_q[NSRC-1:HALF];
            K_TY_LO:   rd_word = ty_q[HALF-1:0];
            K_PRIO:    rd_word = prio_q[grp*DATA_W +: DATA_W];
            K_RAW_HI:  rd_word = pend_q[NSRC-1:HALF];
            K_RAW_LO:  rd_word = pend_q[HALF-1:0];
            K_NPND_HI: rd_word = nview[NSRC-1:HALF];
            K_NPND_LO: rd_word = nview[HALF-1:0];
            K_FPND_HI: rd_word = fview[NSRC-1:HALF];
            K_FPND_LO: rd_word = fview[HALF-1:0];
            K_VEC0:    rd_word = VEC0_VALUE;
            default:   rd_word = '0;
        endcase
    end

endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
    import irqb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int PRIO_W = 4,
    parameter int MASK_W = 5,
    localparam int NSRC  = 2 * DATA_W,
    localparam int NGRP  = (NSRC * PRIO_W) / DATA_W,
    localparam int GRP_W = $clog2(NGRP)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [NSRC-1:0]         src_lvl,
    output logic                    fiq_req,
    output logic [NSRC-1:0]         norm_pend,
    output logic [NSRC-1:0]         fast_pend,
    output logic [NSRC*PRIO_W-1:0]  prio_all,
    output logic [MASK_W-1:0]       nmask
);

    reg_kind_e              kind;
    logic [GRP_W-1:0]       grp;
    logic [NSRC-1:0]        pend_q;
    logic [NSRC-1:0]        en_q;
    logic [NSRC-1:0]        ty_q;
    logic [NSRC*PRIO_W-1:0] prio_q;
    logic [DATA_W-1:0]      ctl_q;
    logic [MASK_W-1:0]      mask_q;
    logic [DATA_W-1:0]      rd_word;
    logic [DATA_W-1:0]      rdata_q;
    logic                   wr_stb;
    logic                   rd_stb;

    assign wr_stb = bus_sel & bus_we;
    assign rd_stb = bus_sel & ~bus_we;

    irqb_decode #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .grp  (grp)
    );

    irqb_state #(.DATA_W(DATA_W), .PRIO_W(PRIO_W), .MASK_W(MASK_W), .GRP_W(GRP_W)) u_st (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .kind    (kind),
        .grp     (grp),
        .wdata   (bus_wdata),
        .src_lvl (src_lvl),
        .pend_q  (pend_q),
        .en_q    (en_q),
        .ty_q    (ty_q),
        .prio_q  (prio_q),
        .ctl_q   (ctl_q),
        .mask_q  (mask_q)
    );

    irqb_rdmux #(.DATA_W(DATA_W), .PRIO_W(PRIO_W), .MASK_W(MASK_W), .GRP_W(GRP_W)) u_rd (
        .kind    (kind),
        .grp     (grp),
        .pend_q  (pend_q),
        .en_q    (en_q),
        .ty_q    (ty_q),
        .prio_q  (prio_q),
        .ctl_q   (ctl_q),
        .mask_q  (mask_q),
        .rd_word (rd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_stb) rdata_q <= rd_word;
    end

    assign bus_rdata = rdata_q;
    assign norm_pend = pend_q & en_q & ~ty_q;
    assign fast_pend = pend_q & en_q & ty_q;
    assign fiq_req   = |fast_pend;
    assign prio_all  = prio_q;
    assign nmask     = mask_q;

endmodule

// File: rtl/irqb_chk.sv
module irqb_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_sel,
    input logic         bus_we,
    input logic [11:0]  bus_addr,
    input logic [31:0]  bus_wdata,
    input logic [31:0]  bus_rdata,
    input logic [4:0]   nmask,
    input logic [255:0] prio_all,
    input logic [63:0]  en_q,
    input logic [63:0]  pend_q
);

    logic rd, wr, in_vec;
    assign rd     = bus_sel && !bus_we;
    assign wr     = bus_sel && bus_we;
    assign in_vec = (bus_addr >= 12'h100) && (bus_addr <= 12'h2FC);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (nmask == 5'h1F) && (en_q == '0) && (pend_q == '0));

    assert_numreg_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd && (bus_addr == 12'h008 || bus_addr == 12'h00C) |=> bus_rdata == 32'h0);

    assert_ennum_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr && bus_addr == 12'h008 |=> en_q[$past(bus_wdata[5:0])]);

    assert_force_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr && bus_addr == 12'h054 |=> pend_q[31:0] == $past(bus_wdata));

    assert_force_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr && bus_addr == 12'h050 |=> pend_q[63:32] == $past(bus_wdata));

    assert_vec_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr && in_vec |=> $stable(prio_all) && $stable(nmask) && $stable(en_q));

    assert_vec0_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd && bus_addr == 12'h100 |=> bus_rdata == 32'h4);

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd && ((bus_addr >= 12'h068 && bus_addr < 12'h100) || bus_addr > 12'h2FC)
        |=> bus_rdata == 32'h0);

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata));

endmodule

bind irq_regbank irqb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .nmask     (nmask),
    .prio_all  (prio_all),
    .en_q      (en_q),
    .pend_q    (pend_q)
);

// File: tb/sim_irq_regbank.sv
module sim_irq_regbank;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_we = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [63:0]  src_lvl = '0;
    logic         fiq_req;
    logic [63:0]  norm_pend;
    logic [63:0]  fast_pend;
    logic [255:0] prio_all;
    logic [4:0]   nmask;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_regbank u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_lvl(src_lvl), .fiq_req(fiq_req), .norm_pend(norm_pend),
        .fast_pend(fast_pend), .prio_all(prio_all), .nmask(nmask)
    );

    localparam bit WR = 1'b1;
    localparam bit RD = 1'b0;
    localparam int NVEC = 44;
    // {req[3:0], write, addr[11:0], data/expected[31:0]}
    localparam logic [48:0] TBL [NVEC] = '{
        {4'd3,  WR, 12'h008, 32'h0000_0005},
        {4'd3,  WR, 12'h008, 32'h0000_0047},   // R3 low six bits: source 7
        {4'd3,  RD, 12'h014, 32'h0000_00A0},
        {4'd3,  RD, 12'h008, 32'h0000_0000},
        {4'd3,  WR, 12'h00C, 32'h0000_0005},
        {4'd3,  RD, 12'h014, 32'h0000_0080},
        {4'd3,  RD, 12'h00C, 32'h0000_0000},
        {4'd4,  WR, 12'h010, 32'hDEAD_BEEF},   // R4 enable high
        {4'd4,  RD, 12'h010, 32'hDEAD_BEEF},
        {4'd4,  RD, 12'h014, 32'h0000_0080},
        {4'd4,  WR, 12'h018, 32'h0000_00F0},
        {4'd4,  WR, 12'h01C, 32'h0000_0001},
        {4'd4,  RD, 12'h018, 32'h0000_00F0},
        {4'd4,  RD, 12'h01C, 32'h0000_0001},
        {4'd9,  WR, 12'h004, 32'hFFFF_FFE3},   // R9 mask keeps 5 bits
        {4'd9,  RD, 12'h004, 32'h0000_0003},
        {4'd5,  WR, 12'h020, 32'h8765_4321},   // R5 sources 56..63
        {4'd5,  WR, 12'h03C, 32'h0000_00A0},   // R5 sources 0..7
        {4'd5,  RD, 12'h020, 32'h8765_4321},
        {4'd5,  RD, 12'h03C, 32'h0000_00A0},
        {4'd4,  WR, 12'h000, 32'h1234_5678},
        {4'd4,  RD, 12'h000, 32'h1234_5678},
        {4'd6,  WR, 12'h054, 32'h0000_0081},   // R6 force low
        {4'd6,  RD, 12'h04C, 32'h0000_0081},
        {4'd6,  RD, 12'h054, 32'h0000_0000},
        {4'd7,  RD, 12'h05C, 32'h0000_0080},   // R7 normal low
        {4'd7,  RD, 12'h064, 32'h0000_0000},
        {4'd6,  WR, 12'h050, 32'h0000_00FF},
        {4'd6,  RD, 12'h048, 32'h0000_00FF},
        {4'd7,  RD, 12'h058, 32'h0000_000F},
        {4'd7,  RD, 12'h060, 32'h0000_00E0},
        {4'd10, WR, 12'h04C, 32'h0000_FFFF},   // R10 read-only raw
        {4'd10, RD, 12'h04C, 32'h0000_0081},
        {4'd10, WR, 12'h05C, 32'hFFFF_FFFF},
        {4'd10, RD, 12'h05C, 32'h0000_0080},
        {4'd10, WR, 12'h040, 32'hFFFF_FFFF},
        {4'd10, RD, 12'h040, 32'h0000_0000},
        {4'd10, WR, 12'h100, 32'h0000_0055},
        {4'd10, RD, 12'h100, 32'h0000_0004},
        {4'd10, RD, 12'h104, 32'h0000_0000},
        {4'd10, RD, 12'h004, 32'h0000_0003},
        {4'd11, WR, 12'h068, 32'h0000_1234},   // R11 unmapped
        {4'd11, RD, 12'h068, 32'h0000_0000},
        {4'd11, RD, 12'hFFC, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        src_lvl = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        do_reset();

        // R1 reset state
        check("R1 fiq_req", 64'(fiq_req), 64'h0);
        check("R1 norm_pend", norm_pend, 64'h0);
        check("R1 prio_all", 64'(|prio_all), 64'h0);
        check("R1 rdata", 64'(bus_rdata), 64'h0);
        bus_rd(12'h004, rv); check("R1 mask", 64'(rv), 64'h1F);
        bus_rd(12'h014, rv); check("R1 enable low", 64'(rv), 64'h0);
        bus_rd(12'h04C, rv); check("R1 raw low", 64'(rv), 64'h0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            if (TBL[i][44]) begin
                bus_wr(TBL[i][43:32], TBL[i][31:0]);
            end else begin
                bus_rd(TBL[i][43:32], rv);
                check($sformatf("R%0d table entry %0d", TBL[i][48:45], i),
                      64'(rv), 64'(TBL[i][31:0]));
            end
        end

        // R5 port view of priorities, R7/R8 port views
        check("R5 prio src56", 64'(prio_all[56*4 +: 4]), 64'h1);
        check("R5 prio src63", 64'(prio_all[63*4 +: 4]), 64'h8);
        check("R5 prio src1",  64'(prio_all[1*4 +: 4]),  64'hA);
        check("R7 norm_pend", norm_pend, 64'h0000_000F_0000_0080);
        check("R7 fast_pend", fast_pend, 64'h0000_00E0_0000_0000);
        check("R8 fiq high", 64'(fiq_req), 64'h1);
        check("R9 nmask port", 64'(nmask), 64'h3);
        bus_wr(12'h010, 32'h0);
        check("R8 fiq low after disable", 64'(fiq_req), 64'h0);

        // R2 input edge capture
        do_reset();
        bus_wr(12'h014, 32'hFFFF_FFFF);
        @(negedge clk); src_lvl[3] = 1'b1;
        @(negedge clk);
        check("R2 rise captured", 64'(norm_pend[3]), 64'h1);
        bus_wr(12'h054, 32'h0);
        repeat (2) @(negedge clk);
        check("R2 steady input keeps forced value", 64'(norm_pend[3]), 64'h0);

        // R6 force wins over same-cycle input change
        @(negedge clk);
        src_lvl[4] = 1'b1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 12'h054; bus_wdata = 32'h0;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        check("R6 force beats input", 64'(norm_pend[4]), 64'h0);
        @(negedge clk);
        check("R6 force persists", 64'(norm_pend[4]), 64'h0);

        // R2 fall
        src_lvl[5] = 1'b1;
        @(negedge clk);
        check("R2 rise src5", 64'(norm_pend[5]), 64'h1);
        src_lvl[5] = 1'b0;
        @(negedge clk);
        check("R2 fall src5", 64'(norm_pend[5]), 64'h0);

        // R7/R8 fast source
        bus_wr(12'h01C, 32'h0000_0020);
        src_lvl[5] = 1'b1;
        @(negedge clk);
        check("R8 fiq from src5", 64'(fiq_req), 64'h1);
        check("R7 fast view src5", fast_pend, 64'h20);
        check("R7 normal view excludes fast", 64'(norm_pend[5]), 64'h0);

        // R12 rdata held across writes
        bus_rd(12'h01C, rv);
        check("R12 read type low", 64'(rv), 64'h20);
        bus_wr(12'h000, 32'hCAFE_0001);
        repeat (2) @(negedge clk);
        check("R12 rdata held", 64'(bus_rdata), 64'h20);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule